// File: doc/BRIEF.md
# Strap-Pin Slave Address Sequencer

This block lets a host choose the serial slave address of the device at run time. A shared interrupt line carries a strap: an external pull-up, or nothing, on the board. When the host writes the start bit of the control word, the block stops driving the line and leaves it at high impedance. It then waits a settling window so that a pull-up has time to raise the line. At the end of the window it samples the line through a synchronizer, latches one of two slave addresses and drives the line again.

The window is counted in pulses of a timebase tick input that the surrounding chip supplies, nominally one pulse per microsecond. A 2-bit select that is written together with the start bit picks one of four window lengths, from the full base length down to one eighth of it. A busy flag covers the whole sequence. While it is high, further start requests are dropped.

Top module: `strap_addr_seq`

## Requirements
- R1: After synchronous reset, `slave_addr` is 7'h10, `pin_oe` is 1 and `busy` is 0.
- R2: A write (`wr_en`=1) with `wr_start`=1 while idle makes `busy`=1 and `pin_oe`=0 from the next clock edge.
- R3: A write with `wr_start`=0 starts nothing: `busy` stays 0, `pin_oe` stays 1 and `slave_addr` is unchanged.
- R4: The window lasts BASE_TICKS >> `wr_win` ticks. With default BASE_TICKS=160, select 0 gives 160, 1 gives 80, 2 gives 40 and 3 gives 20 ticks. `busy` stays high while exactly that many tick pulses are seen, and it falls at the edge that takes the last one.
- R5: At the end of the window, a synchronized pin level of 0 latches 7'h10 (write form 0x20) and a level of 1 latches 7'h11 (write form 0x22). `slave_addr` changes at no other time.
- R6: At the clock edge that ends the window, `busy` drops to 0, `pin_oe` returns to 1 and `slave_addr` takes its new value, all together.
- R7: `pin_oe` is 0 exactly while `busy` is 1.
- R8: A start request that arrives while `busy` is 1 is ignored, and the running window keeps its length.
- R9: The window select is taken at the start. A later write that changes `wr_win` does not alter a running window.
- R10: `pin_in` passes through a two-flop synchronizer. The decision uses the pin level sampled two clock edges before the edge that ends the window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Control-register write strobe |
| wr_start | input | 1 | Start bit of the written control word |
| wr_win | input | 2 | Window select of the written control word |
| tick | input | 1 | Timebase pulse, one cycle wide |
| pin_in | input | 1 | Level read back from the strap pin |
| pin_oe | output | 1 | Strap pin output-driver enable (0 = high impedance) |
| busy | output | 1 | Sequence in progress |
| slave_addr | output | 7 | Latched 7-bit slave address |

## Verification
The bench builds the block with BASE_TICKS=16, which gives windows of 16, 8, 4 and 2 ticks. At that size every combination of window select and strap level can be swept, with the tick count per window checked against a shift computed in the bench. The short windows make it practical to run overlapping starts and mid-window select writes. They also allow a back-to-back tick mode, in which the final tick edge is known to the cycle, so that the two-flop synchronizer delay can be separated from a one-flop or direct path.

// File: rtl/strap_pkg.sv
package strap_pkg;
  typedef enum logic [0:0] {
    SEQ_IDLE = 1'b0,
    SEQ_WAIT = 1'b1
  } seq_state_t;

  localparam int unsigned SEL_W = 2;
endpackage

// File: rtl/strap_sync.sv
module strap_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];

  // R10: the output follows the input after the full chain delay
  p_sync_delay_r10: assert property (@(posedge clk) disable iff (rst)
    !$past(rst, STAGES) |-> (q == $past(d, STAGES)));
endmodule

// File: rtl/strap_window_timer.sv
module strap_window_timer #(
  parameter int unsigned BASE_TICKS = 160,
  parameter int unsigned SEL_W      = 2,
  localparam int unsigned CNT_W     = $clog2(BASE_TICKS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [SEL_W-1:0] sel,
  input  logic             tick,
  output logic             running,
  output logic             expire
);
  logic [CNT_W-1:0] rem;
  logic [CNT_W-1:0] load_val;

  always_comb begin
    load_val = CNT_W'(BASE_TICKS >> sel);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rem     <= '0;
      running <= 1'b0;
    end else if (load) begin
      rem     <= load_val;
      running <= 1'b1;
    end else if (running && tick) begin
      if (rem == CNT_W'(1)) begin
        running <= 1'b0;
        rem     <= '0;
      end else begin
        rem <= rem - CNT_W'(1);
      end
    end
  end

  assign expire = running && tick && (rem == CNT_W'(1));

  // R4: each tick inside the window removes exactly one unit
  p_tick_step_r4: assert property (@(posedge clk) disable iff (rst)
    (running && tick && !load && rem != CNT_W'(1)) |=> (rem == $past(rem) - CNT_W'(1)));
  // R9: the remaining count only moves on ticks once loaded
  p_hold_no_tick_r9: assert property (@(posedge clk) disable iff (rst)
    (running && !tick && !load) |=> $stable(rem));
  // R4: a loaded window is never empty
  p_load_nonzero_r4: assert property (@(posedge clk) disable iff (rst)
    load |=> (running && rem != '0));
endmodule

// File: rtl/strap_seq_ctrl.sv
module strap_seq_ctrl
  import strap_pkg::*;
#(
  parameter int unsigned ADDR_W    = 7,
  parameter logic [ADDR_W-1:0] ADDR_LOW  = 7'h10,
  parameter logic [ADDR_W-1:0] ADDR_HIGH = 7'h11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_req,
  input  logic              expire,
  input  logic              pin_level,
  output logic              load,
  output logic              pin_oe,
  output logic              busy,
  output logic [ADDR_W-1:0] addr
);
  seq_state_t state;

  assign load = start_req && (state == SEQ_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= SEQ_IDLE;
      pin_oe <= 1'b1;
      busy   <= 1'b0;
      addr   <= ADDR_LOW;
    end else begin
      case (state)
        SEQ_IDLE: begin
          if (start_req) begin
            state  <= SEQ_WAIT;
            pin_oe <= 1'b0;
            busy   <= 1'b1;
          end
        end
        SEQ_WAIT: begin
          if (expire) begin
            state  <= SEQ_IDLE;
            pin_oe <= 1'b1;
            busy   <= 1'b0;
            addr   <= pin_level ? ADDR_HIGH : ADDR_LOW;
          end
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end

  // R2: an accepted start releases the pin on the next edge
  p_start_release_r2: assert property (@(posedge clk) disable iff (rst)
    (start_req && !busy) |=> (busy && !pin_oe));
  // R7: driver enable is the inverse of busy
  p_oe_vs_busy_r7: assert property (@(posedge clk) disable iff (rst)
    pin_oe == !busy);
  // R8: a start while busy does not end or restart the sequence
  p_ignore_busy_r8: assert property (@(posedge clk) disable iff (rst)
    (busy && !expire) |=> busy);
  // R5: the address only changes at the end of a window
  p_addr_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !expire |=> $stable(addr));
  // R6: the end of a window restores the driver and latches the sample
  p_finish_r6: assert property (@(posedge clk) disable iff (rst)
    (busy && expire) |=> (!busy && pin_oe &&
                          addr == ($past(pin_level) ? ADDR_HIGH : ADDR_LOW)));
endmodule

// File: rtl/strap_addr_seq.sv
module strap_addr_seq #(
  parameter int unsigned BASE_TICKS  = 160,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned ADDR_W      = 7,
  parameter logic [ADDR_W-1:0] ADDR_LOW  = 7'h10,
  parameter logic [ADDR_W-1:0] ADDR_HIGH = 7'h11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              wr_start,
  input  logic [1:0]        wr_win,
  input  logic              tick,
  input  logic              pin_in,
  output logic              pin_oe,
  output logic              busy,
  output logic [ADDR_W-1:0] slave_addr
);
  logic start_req;
  logic load;
  logic expire;
  logic running;
  logic pin_sync;

  assign start_req = wr_en && wr_start;

  strap_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pin_in),
    .q   (pin_sync)
  );

  strap_window_timer #(
    .BASE_TICKS (BASE_TICKS),
    .SEL_W      (strap_pkg::SEL_W)
  ) u_timer (
    .clk     (clk),
    .rst     (rst),
    .load    (load),
    .sel     (wr_win),
    .tick    (tick),
    .running (running),
    .expire  (expire)
  );

  strap_seq_ctrl #(
    .ADDR_W    (ADDR_W),
    .ADDR_LOW  (ADDR_LOW),
    .ADDR_HIGH (ADDR_HIGH)
  ) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .start_req (start_req),
    .expire    (expire),
    .pin_level (pin_sync),
    .load      (load),
    .pin_oe    (pin_oe),
    .busy      (busy),
    .addr      (slave_addr)
  );

  // R4: timer and sequencer agree on whether a window is open
  p_timer_matches_busy_r4: assert property (@(posedge clk) disable iff (rst)
    running == busy);
  // R3: a write without the start bit never opens a window
  p_no_start_r3: assert property (@(posedge clk) disable iff (rst)
    (!busy && !(wr_en && wr_start)) |=> !busy);
endmodule

// File: tb/sim_strap_addr_seq.sv
module sim_strap_addr_seq;
  localparam int CLK_PERIOD = 10;
  localparam int BASE = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0, wr_start = 1'b0;
  logic [1:0] wr_win = 2'd0;
  logic tick = 1'b0;
  logic pin_in = 1'b0;
  logic pin_oe, busy;
  logic [6:0] slave_addr;

  int n_vec = 0;
  int n_bad = 0;
  int busy_ticks = 0;
  int oe_errs = 0;
  int cyc = 0;
  bit fast_tick = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  strap_addr_seq #(.BASE_TICKS(BASE)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_start(wr_start), .wr_win(wr_win),
    .tick(tick), .pin_in(pin_in), .pin_oe(pin_oe), .busy(busy),
    .slave_addr(slave_addr)
  );

  initial forever begin
    @(negedge clk);
    cyc++;
    tick = fast_tick ? 1'b1 : (cyc % 3 == 0);
  end

  always @(posedge clk) begin
    if (!rst && busy && tick) busy_ticks++;
    if (!rst && (pin_oe == busy)) oe_errs++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic write(input bit st, input logic [1:0] w);
    @(negedge clk);
    wr_en = 1'b1; wr_start = st; wr_win = w;
    @(negedge clk);
    wr_en = 1'b0; wr_start = 1'b0;
  endtask

  task automatic wait_idle();
    int guard = 0;
    while (busy && guard < 1000) begin
      @(negedge clk);
      guard++;
    end
  endtask

  task automatic run_seq(input logic [1:0] sel, input bit pin);
    int exp_ticks = BASE >> sel;
    pin_in = pin;
    repeat (3) @(negedge clk);
    busy_ticks = 0;
    write(1'b1, sel);
    chk(busy == 1'b1 && pin_oe == 1'b0, "R2", {busy, pin_oe}, 2);
    wait_idle();
    chk(busy_ticks == exp_ticks, "R4", busy_ticks, exp_ticks);
    chk(slave_addr == (pin ? 7'h11 : 7'h10), "R5", slave_addr, pin ? 17 : 16);
    chk(pin_oe == 1'b1 && busy == 1'b0, "R6", {busy, pin_oe}, 1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(slave_addr == 7'h10, "R1", slave_addr, 16);
    chk(pin_oe == 1'b1 && busy == 1'b0, "R1", {busy, pin_oe}, 1);

    // R3: write without start bit
    write(1'b0, 2'd2);
    @(negedge clk);
    chk(busy == 1'b0 && pin_oe == 1'b1 && slave_addr == 7'h10, "R3",
        {busy, pin_oe}, 1);

    // R4, R5, R6: sweep select and strap level
    for (int s = 0; s < 4; s++)
      for (int p = 0; p < 2; p++)
        run_seq(2'(s), 1'(p));

    // R3 again after a high address was latched
    write(1'b0, 2'd0);
    @(negedge clk);
    chk(busy == 1'b0 && slave_addr == 7'h11, "R3", slave_addr, 17);

    // R8: second start mid-window is ignored
    pin_in = 1'b0;
    repeat (3) @(negedge clk);
    busy_ticks = 0;
    write(1'b1, 2'd0);
    repeat (10) @(negedge clk);
    write(1'b1, 2'd3);
    wait_idle();
    chk(busy_ticks == BASE, "R8", busy_ticks, BASE);

    // R9: window select change mid-run has no effect
    busy_ticks = 0;
    write(1'b1, 2'd1);
    repeat (4) @(negedge clk);
    write(1'b0, 2'd3);
    wait_idle();
    chk(busy_ticks == (BASE >> 1), "R9", busy_ticks, BASE >> 1);

    // R10: back-to-back ticks, pin falls right after the start edge
    fast_tick = 1'b1;
    pin_in = 1'b1;
    repeat (4) @(negedge clk);
    @(negedge clk);
    wr_en = 1'b1; wr_start = 1'b1; wr_win = 2'd3;
    @(negedge clk);
    wr_en = 1'b0; wr_start = 1'b0;
    pin_in = 1'b0;
    wait_idle();
    chk(slave_addr == 7'h11, "R10", slave_addr, 17);
    fast_tick = 1'b0;
    run_seq(2'd3, 1'b0);

    chk(oe_errs == 0, "R7", oe_errs, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule